// File: doc/BRIEF.md
# Bus Grant and Data Phase Timeout Monitor

This block runs next to the arbiter of a host-side PCI bus and watches what happens after each grant. It detects two kinds of stall: a master that holds the grant but never drives FRAME# low, and a target that leaves a data phase open by asserting neither TRDY# nor STOP#. The target limit is longer for the first data phase of a transaction than for the phases after it.

The first fault found is latched in a 32-bit status word. Software reads the word and clears a bit by writing a 1 to it. Only one source is held at a time, so the status keeps the origin of the first problem until software acknowledges it. A two-bit enable input selects which recorded sources drive the registered interrupt line. A source is recorded whether or not its enable bit is set.

Top module: `pci_tmo_mon`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rd_data` reads 0 and `irq` is low.
- R2: If `gnt` is high and FRAME# is sampled high on 16 consecutive edges after the edge that first saw the grant, bit 13 of `rd_data` (master stall) reads 1 from the next edge on.
- R3: FRAME# sampled low on the 16th of those edges prevents the master stall. Dropping `gnt` before FRAME# goes low cancels the watch and records nothing.
- R4: After the edge that first samples FRAME# low, if the first data phase is not finished within 16 edges, bit 12 of `rd_data` (target stall) reads 1 from the next edge on.
- R5: For the second and later data phases of the same transaction, the target stall limit is 8 edges, counted from the edge that completed the previous phase.
- R6: A data phase ends when IRDY# and TRDY# are sampled low together, and the count then restarts. STOP# sampled low, or FRAME# and IRDY# both sampled high, ends the watch with no fault.
- R7: Only the first fault is held. While either status bit is 1, a new fault of either kind sets nothing, and at most one status bit is ever 1.
- R8: A source whose enable bit is 0 still sets its status bit, but does not raise `irq`.
- R9: `irq` is a register holding the OR of (status bit AND enable), with `irq_en[1]` for bit 13 and `irq_en[0]` for bit 12. It stays high until the bit is cleared, and writing 1 to a set bit with `wr_en` clears it.
- R10: When a fault and a write of 1 to the same status bit land on the same edge, the bit ends up set.
- R11: All bits of `rd_data` other than 13 and 12 always read 0, and writing 1s to them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| gnt | input | 1 | Grant currently given to a master, active high |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| stop_n | input | 1 | STOP#, active low |
| wr_en | input | 1 | Status write strobe (write 1 to clear) |
| wr_data | input | 32 | Status write data |
| irq_en | input | 2 | Interrupt enables: [1] master stall, [0] target stall |
| rd_data | output | 32 | Status word: bit 13 master stall, bit 12 target stall |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `irq_en`, `wr_en` and `wr_data` are stable around each rising edge, and that the bus lines follow PCI order: FRAME# and IRDY# are released together when the bus goes idle, and a new transaction starts only after an idle cycle. The stimulus changes every input only on the falling clock edge, always returns the bus to idle with both lines high and `gnt` low between scenarios, and clears the status word before the next scenario. Data phases are closed only with IRDY# already low, so every completion the monitor sees is a legal one.

// File: rtl/pci_tmo_pkg.sv
package pci_tmo_pkg;

  // Status bit positions (software decodes these)
  localparam int MB_BIT = 13;  // master never started
  localparam int TT_BIT = 12;  // target stalled a data phase

  typedef enum logic [1:0] {
    G_IDLE,
    G_WAIT,
    G_BUSY,
    G_HOLD
  } gstate_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_DATA,
    P_END
  } pstate_t;

endpackage

// File: rtl/pci_tmo_grant_watch.sv
module pci_tmo_grant_watch
  import pci_tmo_pkg::*;
#(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic gnt,
  input  logic frame_n,
  input  logic irdy_n,
  output logic fault
);

  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  gstate_t       state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= G_IDLE;
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      fault <= 1'b0;
      case (state)
        G_IDLE: begin
          if (gnt) begin
            if (!frame_n) begin
              state <= G_BUSY;
            end else begin
              state <= G_WAIT;
              cnt   <= '0;
            end
          end
        end
        G_WAIT: begin
          if (!frame_n) begin
            state <= G_BUSY;
          end else if (!gnt) begin
            state <= G_IDLE;
          end else if (cnt == LAST) begin
            fault <= 1'b1;
            state <= G_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        G_BUSY: begin
          if (frame_n && irdy_n) state <= G_IDLE;
        end
        G_HOLD: begin
          if (!frame_n)  state <= G_BUSY;
          else if (!gnt) state <= G_IDLE;
        end
        default: state <= G_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_tmo_phase_watch.sv
module pci_tmo_phase_watch
  import pci_tmo_pkg::*;
#(
  parameter int FIRST_LIMIT = 16,
  parameter int NEXT_LIMIT  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic stop_n,
  output logic fault
);

  localparam int MAXL = (FIRST_LIMIT > NEXT_LIMIT) ? FIRST_LIMIT : NEXT_LIMIT;
  localparam int CW   = (MAXL > 2) ? $clog2(MAXL) : 1;
  localparam logic [CW-1:0] FIRST_LAST = CW'(FIRST_LIMIT - 1);
  localparam logic [CW-1:0] NEXT_LAST  = CW'(NEXT_LIMIT - 1);

  pstate_t       state;
  logic [CW-1:0] cnt;
  logic          first;
  logic [CW-1:0] last_cnt;
  logic          phase_done;
  logic          bus_idle;

  always_comb begin
    last_cnt   = first ? FIRST_LAST : NEXT_LAST;
    phase_done = !irdy_n && !trdy_n;
    bus_idle   = frame_n && irdy_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= P_IDLE;
      cnt   <= '0;
      first <= 1'b1;
      fault <= 1'b0;
    end else begin
      fault <= 1'b0;
      case (state)
        P_IDLE: begin
          if (!frame_n) begin
            state <= P_DATA;
            cnt   <= '0;
            first <= 1'b1;
          end
        end
        P_DATA: begin
          if (bus_idle) begin
            state <= P_IDLE;
          end else if (!stop_n) begin
            state <= P_END;
          end else if (phase_done) begin
            if (frame_n) begin
              state <= P_END;
            end else begin
              cnt   <= '0;
              first <= 1'b0;
            end
          end else if (cnt == last_cnt) begin
            fault <= 1'b1;
            state <= P_END;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_END: begin
          if (bus_idle) state <= P_IDLE;
        end
        default: state <= P_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_tmo_stat_reg.sv
module pci_tmo_stat_reg
  import pci_tmo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mb_fault,
  input  logic              tt_fault,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        irq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  // stat[1] = master stall, stat[0] = target stall
  logic [1:0] stat;
  logic [1:0] clr;
  logic [1:0] kept;
  logic [1:0] stat_nxt;
  logic       unused_wr;

  assign unused_wr = ^{wr_data[DATA_W-1:MB_BIT+1], wr_data[TT_BIT-1:0]};

  always_comb begin
    clr      = wr_en ? {wr_data[MB_BIT], wr_data[TT_BIT]} : 2'b00;
    kept     = stat & ~clr;
    stat_nxt = kept;
    if (kept == 2'b00) begin
      if (mb_fault)      stat_nxt = 2'b10;
      else if (tt_fault) stat_nxt = 2'b01;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= 2'b00;
      irq  <= 1'b0;
    end else begin
      stat <= stat_nxt;
      irq  <= |(stat_nxt & irq_en);
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[MB_BIT] = stat[1];
    rd_data[TT_BIT] = stat[0];
  end

endmodule

// File: rtl/pci_tmo_mon.sv
module pci_tmo_mon
  import pci_tmo_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int MB_LIMIT       = 16,
  parameter int TT_FIRST_LIMIT = 16,
  parameter int TT_NEXT_LIMIT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gnt,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              stop_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        irq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  logic mb_fault;
  logic tt_fault;

  pci_tmo_grant_watch #(
    .LIMIT(MB_LIMIT)
  ) u_grant (
    .clk    (clk),
    .rst    (rst),
    .gnt    (gnt),
    .frame_n(frame_n),
    .irdy_n (irdy_n),
    .fault  (mb_fault)
  );

  pci_tmo_phase_watch #(
    .FIRST_LIMIT(TT_FIRST_LIMIT),
    .NEXT_LIMIT (TT_NEXT_LIMIT)
  ) u_phase (
    .clk    (clk),
    .rst    (rst),
    .frame_n(frame_n),
    .irdy_n (irdy_n),
    .trdy_n (trdy_n),
    .stop_n (stop_n),
    .fault  (tt_fault)
  );

  pci_tmo_stat_reg #(
    .DATA_W(DATA_W)
  ) u_stat (
    .clk     (clk),
    .rst     (rst),
    .mb_fault(mb_fault),
    .tt_fault(tt_fault),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .irq_en  (irq_en),
    .rd_data (rd_data),
    .irq     (irq)
  );

endmodule

// File: rtl/pci_tmo_mon_chk.sv
module pci_tmo_mon_chk
  import pci_tmo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_clr,
  input logic [1:0]        irq_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq
);

  logic [1:0] st;
  assign st = {rd_data[MB_BIT], rd_data[TT_BIT]};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !irq));

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[DATA_W-1:MB_BIT+1] == '0) && (rd_data[TT_BIT-1:0] == '0));

  // R7
  single_src_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st));

  // R7
  no_late_tt_chk: assert property (@(posedge clk) disable iff (rst)
    (st[1] && !(wr_en && wr_clr[1])) |=> !st[0]);

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(st & $past(irq_en)));

  // R9
  sticky_mb_chk: assert property (@(posedge clk) disable iff (rst)
    (st[1] && !(wr_en && wr_clr[1])) |=> st[1]);

  // R9
  sticky_tt_chk: assert property (@(posedge clk) disable iff (rst)
    (st[0] && !(wr_en && wr_clr[0])) |=> st[0]);

endmodule

bind pci_tmo_mon pci_tmo_mon_chk #(
  .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .wr_clr ({wr_data[pci_tmo_pkg::MB_BIT], wr_data[pci_tmo_pkg::TT_BIT]}),
  .irq_en (irq_en),
  .rd_data(rd_data),
  .irq    (irq)
);

// File: tb/pci_tmo_mon_tb.sv
module pci_tmo_mon_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MB_MASK = 32'h0000_2000;
  localparam logic [31:0] TT_MASK = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gnt = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic        stop_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  irq_en = 2'b11;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_tmo_mon u_dut (
    .clk(clk), .rst(rst), .gnt(gnt), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    gnt = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
    step(3);
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    step(1);
    wr_en = 1'b0; wr_data = '0;
    step(1);
  endtask

  task automatic t_reset();
    check("R1 status after reset", rd_data, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_master_stall();
    irq_en = 2'b11;
    gnt = 1'b1;
    step(17);
    check("R2 no fault before limit", rd_data, 32'h0);
    step(1);
    check("R2 master stall recorded", rd_data, MB_MASK);
    check("R9 irq raised", {31'b0, irq}, 32'h1);
    step(5);
    check("R9 irq held until cleared", {31'b0, irq}, 32'h1);
    gnt = 1'b0;
    wr_en = 1'b1; wr_data = MB_MASK;
    step(1);
    wr_en = 1'b0; wr_data = '0;
    check("R9 write 1 clears bit 13", rd_data, 32'h0);
    check("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    bus_idle();
  endtask

  task automatic t_master_ok();
    gnt = 1'b1;
    step(16);
    frame_n = 1'b0; irdy_n = 1'b0;
    step(10);
    check("R3 FRAME on last edge avoids fault", rd_data, 32'h0);
    bus_idle();
    step(5);
    check("R3 still clean after release", rd_data, 32'h0);
    gnt = 1'b1;
    step(8);
    gnt = 1'b0;
    step(20);
    check("R3 grant removal cancels", rd_data, 32'h0);
    bus_idle();
  endtask

  task automatic t_target_first();
    frame_n = 1'b0; irdy_n = 1'b0;
    step(17);
    check("R4 no fault before first-phase limit", rd_data, 32'h0);
    step(1);
    check("R4 target stall recorded", rd_data, TT_MASK);
    bus_idle();
    clear_all();
    frame_n = 1'b0; irdy_n = 1'b0;
    step(16);
    trdy_n = 1'b0; frame_n = 1'b1;
    step(1);
    trdy_n = 1'b1; irdy_n = 1'b1;
    step(20);
    check("R6 TRDY on last edge completes phase", rd_data, 32'h0);
    bus_idle();
  endtask

  task automatic t_target_next();
    frame_n = 1'b0; irdy_n = 1'b0;
    step(3);
    trdy_n = 1'b0;
    step(1);
    trdy_n = 1'b1;
    step(8);
    check("R5 no fault before later-phase limit", rd_data, 32'h0);
    step(1);
    check("R5 later-phase stall after 8 edges", rd_data, TT_MASK);
    bus_idle();
    clear_all();
  endtask

  task automatic t_phase_restart();
    frame_n = 1'b0; irdy_n = 1'b0;
    step(10);
    trdy_n = 1'b0; step(1); trdy_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(6);
      trdy_n = 1'b0; step(1); trdy_n = 1'b1;
    end
    step(5);
    check("R6 completed phases restart the count", rd_data, 32'h0);
    bus_idle();
    frame_n = 1'b0; irdy_n = 1'b0;
    step(10);
    stop_n = 1'b0;
    step(1);
    stop_n = 1'b1; frame_n = 1'b1; irdy_n = 1'b1;
    step(30);
    check("R6 STOP ends the watch", rd_data, 32'h0);
    bus_idle();
  endtask

  task automatic t_first_only();
    irq_en = 2'b11;
    gnt = 1'b1;
    step(18);
    gnt = 1'b0;
    step(2);
    frame_n = 1'b0; irdy_n = 1'b0;
    step(18);
    bus_idle();
    check("R7 later target stall not recorded", rd_data, MB_MASK);
    check("R7 irq from first source", {31'b0, irq}, 32'h1);
    clear_all();
    check("R7 cleared", rd_data, 32'h0);
  endtask

  task automatic t_masked();
    irq_en = 2'b01;
    gnt = 1'b1;
    step(18);
    gnt = 1'b0;
    check("R8 disabled source still recorded", rd_data, MB_MASK);
    check("R8 no irq while disabled", {31'b0, irq}, 32'h0);
    irq_en = 2'b11;
    step(1);
    check("R9 irq follows enable", {31'b0, irq}, 32'h1);
    bus_idle();
    clear_all();
  endtask

  task automatic t_priority();
    irq_en = 2'b11;
    frame_n = 1'b0; irdy_n = 1'b0;
    step(18);
    check("R4 setup stall", rd_data, TT_MASK);
    frame_n = 1'b1; irdy_n = 1'b1;
    step(2);
    frame_n = 1'b0; irdy_n = 1'b0;
    step(17);
    wr_en = 1'b1; wr_data = TT_MASK;
    step(1);
    wr_en = 1'b0; wr_data = '0;
    check("R10 fault wins over same-edge clear", rd_data, TT_MASK);
    bus_idle();
    wr_en = 1'b1; wr_data = TT_MASK;
    step(1);
    wr_en = 1'b0; wr_data = '0;
    check("R9 write 1 clears bit 12", rd_data, 32'h0);
  endtask

  task automatic t_reserved();
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    step(1);
    wr_en = 1'b0; wr_data = '0;
    check("R11 reserved bits read 0", rd_data, 32'h0);
    gnt = 1'b1;
    step(18);
    gnt = 1'b0;
    wr_en = 1'b1; wr_data = 32'hFFFF_CFFF;
    step(1);
    wr_en = 1'b0; wr_data = '0;
    check("R11 writes to other bits ignored", rd_data, MB_MASK);
    bus_idle();
    clear_all();
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_master_stall();
    t_master_ok();
    t_target_first();
    t_target_next();
    t_phase_restart();
    t_first_only();
    t_masked();
    t_priority();
    t_reserved();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule